// File: doc/BRIEF.md
# Video FIFO Watermark Priority Request Controller

This block watches the fill level of a video FIFO and tells the memory arbiter how urgently the FIFO needs data. It has two outputs. The normal request stays up whenever overlay is on and the FIFO has room. The urgent request uses two programmable watermarks, counted in 64-byte units, to give hysteresis. It rises when the fill level drains down to the low watermark. It then holds until the fill level climbs back to the high watermark.

Software presents new watermark values on the configuration inputs. The block copies them into its working registers only on a frame-start strobe, so the thresholds never change in the middle of a frame or field. A high watermark of zero means the overlay path is unused, and in that case no urgent request is ever raised. A nonzero high watermark that is paired with a zero low watermark, or with a low watermark that is not below it, is reported as a configuration error, and the urgent request is held off.

Top module: `vfifo_prio_ctrl`

## Requirements
- R1: After reset, `hi_req_o`, `norm_req_o` and `cfg_err_o` are all 0, and both working watermarks are 0.
- R2: The working watermarks load from `start_lvl_i`/`end_lvl_i` only on a clock edge where `frame_start_i` is 1. New values first affect `hi_req_o` one cycle after that edge, and `cfg_err_o` right after that edge. Without the strobe, changes on those inputs have no effect.
- R3: When `hi_req_o` is 0 and the request is permitted, a fill level at or below start×64 bytes sets `hi_req_o` on the next edge.
- R4: Once set, `hi_req_o` stays 1 while the fill level is below end×64 bytes. It clears on the edge after the fill level reaches end×64 or more.
- R5: A working end watermark of 0 keeps `hi_req_o` at 0 from the next edge on, and does not raise `cfg_err_o`.
- R6: `cfg_err_o` is 1 when the working end watermark is nonzero and the start watermark is either 0 or not less than it. While it is 1, `hi_req_o` is 0 from the next edge on.
- R7: With `ovl_en_i` at 0, both `hi_req_o` and `norm_req_o` are 0 on the next edge.
- R8: `norm_req_o` equals, one edge later, `ovl_en_i` AND (fill level < `FIFO_BYTES`).
- R9: While `hi_req_o` is 0, a fill level above start×64 keeps it at 0, including levels below end×64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ovl_en_i | input | 1 | Overlay path enabled |
| frame_start_i | input | 1 | Frame/field boundary strobe; loads new watermarks |
| start_lvl_i | input | 4 | Pending low watermark, in 64-byte units |
| end_lvl_i | input | 4 | Pending high watermark, in 64-byte units |
| fill_bytes_i | input | DEPTH_W (11) | Current FIFO fill level in bytes |
| hi_req_o | output | 1 | Urgent fill request to the arbiter |
| norm_req_o | output | 1 | Normal fill request to the arbiter |
| cfg_err_o | output | 1 | Working watermarks are inconsistent |

## Verification
A wrong hysteresis bit shows up on `hi_req_o` one edge after the fill level crosses a watermark. Probing with fill levels just inside and just outside each band exposes a request that sets or clears one step early or late. A shadow register that loads at the wrong time shows up as `cfg_err_o` changing immediately, and as `hi_req_o` following thresholds that have not been committed yet, within one cycle of the input change. A wrong full comparison appears on `norm_req_o` at exactly `FIFO_BYTES` − 1 versus `FIFO_BYTES`.

// File: rtl/vfp_pkg.sv
package vfp_pkg;
    localparam int WM_W = 4;

    typedef struct packed {
        logic [WM_W-1:0] start_lvl;
        logic [WM_W-1:0] end_lvl;
    } wm_cfg_t;
endpackage

// File: rtl/vfp_shadow.sv
module vfp_shadow
    import vfp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load_i,
    input  wm_cfg_t cfg_i,
    output wm_cfg_t cfg_o,
    output logic    err_o,
    output logic    armed_o
);
    typedef struct packed {
        wm_cfg_t cfg;
    } shadow_t;

    shadow_t st_d, st_q;
    logic    end_zero;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cfg = cfg_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // a zero high mark means the overlay path is unused: quiet, not an error
    assign end_zero = (st_q.cfg.end_lvl == '0);
    assign err_o    = !end_zero &&
                      ((st_q.cfg.start_lvl == '0) ||
                       (st_q.cfg.start_lvl >= st_q.cfg.end_lvl));
    assign armed_o  = !end_zero && !err_o;
    assign cfg_o    = st_q.cfg;
endmodule

// File: rtl/vfp_hyst.sv
module vfp_hyst
    import vfp_pkg::*;
#(
    parameter int DEPTH_W    = 11,
    parameter int UNIT_SHIFT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable_i,
    input  wm_cfg_t            cfg_i,
    input  logic [DEPTH_W-1:0] fill_i,
    output logic               req_o
);
    localparam int LVLB_W = WM_W + UNIT_SHIFT;
    localparam int CW     = ((DEPTH_W > LVLB_W) ? DEPTH_W : LVLB_W) + 1;

    logic [CW-1:0] fill_x, lo_bytes, hi_bytes;
    logic          hi_d, hi_q;

    always_comb begin
        fill_x   = {{(CW-DEPTH_W){1'b0}}, fill_i};
        lo_bytes = {{(CW-WM_W){1'b0}}, cfg_i.start_lvl} << UNIT_SHIFT;
        hi_bytes = {{(CW-WM_W){1'b0}}, cfg_i.end_lvl} << UNIT_SHIFT;
        if (!enable_i) begin
            hi_d = 1'b0;
        end else if (hi_q) begin
            hi_d = (fill_x < hi_bytes);
        end else begin
            hi_d = (fill_x <= lo_bytes);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= 1'b0;
        end else begin
            hi_q <= hi_d;
        end
    end

    assign req_o = hi_q;
endmodule

// File: rtl/vfifo_prio_ctrl.sv
module vfifo_prio_ctrl
    import vfp_pkg::*;
#(
    parameter int DEPTH_W    = 11,
    parameter int UNIT_SHIFT = 6,
    parameter int FIFO_BYTES = 1024
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ovl_en_i,
    input  logic               frame_start_i,
    input  logic [WM_W-1:0]    start_lvl_i,
    input  logic [WM_W-1:0]    end_lvl_i,
    input  logic [DEPTH_W-1:0] fill_bytes_i,
    output logic               hi_req_o,
    output logic               norm_req_o,
    output logic               cfg_err_o
);
    localparam logic [DEPTH_W:0] FULL_X = FIFO_BYTES[DEPTH_W:0];

    wm_cfg_t pend_cfg, act_cfg;
    logic    armed;
    logic    norm_d, norm_q;

    assign pend_cfg.start_lvl = start_lvl_i;
    assign pend_cfg.end_lvl   = end_lvl_i;

    vfp_shadow u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (frame_start_i),
        .cfg_i   (pend_cfg),
        .cfg_o   (act_cfg),
        .err_o   (cfg_err_o),
        .armed_o (armed)
    );

    vfp_hyst #(
        .DEPTH_W    (DEPTH_W),
        .UNIT_SHIFT (UNIT_SHIFT)
    ) u_hyst (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (ovl_en_i && armed),
        .cfg_i    (act_cfg),
        .fill_i   (fill_bytes_i),
        .req_o    (hi_req_o)
    );

    always_comb begin
        norm_d = ovl_en_i && ({1'b0, fill_bytes_i} < FULL_X);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            norm_q <= 1'b0;
        end else begin
            norm_q <= norm_d;
        end
    end

    assign norm_req_o = norm_q;
endmodule

// File: rtl/vfp_checker.sv
module vfp_checker
    import vfp_pkg::*;
#(
    parameter int DEPTH_W    = 11,
    parameter int UNIT_SHIFT = 6,
    parameter int FIFO_BYTES = 1024
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ovl_en_i,
    input logic               frame_start_i,
    input logic [DEPTH_W-1:0] fill_bytes_i,
    input logic               hi_req_o,
    input logic               norm_req_o,
    input logic               cfg_err_o,
    input wm_cfg_t            act_cfg
);
    localparam int CW = DEPTH_W + WM_W + UNIT_SHIFT + 1;

    logic [CW-1:0] f_x, s_x, e_x;
    logic          ok_cfg;
    assign f_x    = {{(CW-DEPTH_W){1'b0}}, fill_bytes_i};
    assign s_x    = {{(CW-WM_W){1'b0}}, act_cfg.start_lvl} << UNIT_SHIFT;
    assign e_x    = {{(CW-WM_W){1'b0}}, act_cfg.end_lvl} << UNIT_SHIFT;
    assign ok_cfg = (act_cfg.start_lvl != '0) && (act_cfg.start_lvl < act_cfg.end_lvl);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!hi_req_o && !norm_req_o) || !rst_n);

    a_r2_hold_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start_i |=> $stable(act_cfg));

    a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_en_i && ok_cfg && !hi_req_o && (f_x <= s_x) |=> hi_req_o);

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_en_i && ok_cfg && hi_req_o && (f_x < e_x) |=> hi_req_o);

    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (f_x >= e_x) |=> !hi_req_o);

    a_r5_end_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cfg.end_lvl == '0) |=> !hi_req_o);

    a_r6_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> !hi_req_o);

    a_r7_ovl_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ovl_en_i |=> !hi_req_o && !norm_req_o);

    a_r8_full: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, fill_bytes_i} >= (DEPTH_W+1)'(FIFO_BYTES)) |=> !norm_req_o);

    a_r9_no_early: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_req_o && (f_x > s_x) |=> !hi_req_o);
endmodule

bind vfifo_prio_ctrl vfp_checker #(
    .DEPTH_W    (DEPTH_W),
    .UNIT_SHIFT (UNIT_SHIFT),
    .FIFO_BYTES (FIFO_BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ovl_en_i      (ovl_en_i),
    .frame_start_i (frame_start_i),
    .fill_bytes_i  (fill_bytes_i),
    .hi_req_o      (hi_req_o),
    .norm_req_o    (norm_req_o),
    .cfg_err_o     (cfg_err_o),
    .act_cfg       (act_cfg)
);

// File: tb/vfifo_prio_ctrl_tb.sv
module vfifo_prio_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH_W    = 11;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ovl_en_i = 1'b0;
    logic               frame_start_i = 1'b0;
    logic [3:0]         start_lvl_i = '0;
    logic [3:0]         end_lvl_i = '0;
    logic [DEPTH_W-1:0] fill_bytes_i = '0;
    logic               hi_req_o, norm_req_o, cfg_err_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vfifo_prio_ctrl #(.DEPTH_W(DEPTH_W), .UNIT_SHIFT(6), .FIFO_BYTES(1024)) u_dut (
        .clk(clk), .rst_n(rst_n), .ovl_en_i(ovl_en_i), .frame_start_i(frame_start_i),
        .start_lvl_i(start_lvl_i), .end_lvl_i(end_lvl_i), .fill_bytes_i(fill_bytes_i),
        .hi_req_o(hi_req_o), .norm_req_o(norm_req_o), .cfg_err_o(cfg_err_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic commit(input logic [3:0] s, input logic [3:0] e);
        start_lvl_i   = s;
        end_lvl_i     = e;
        frame_start_i = 1'b1;
        tick();
        frame_start_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        check("R1 hi_req", hi_req_o, 1'b0);
        check("R1 norm_req", norm_req_o, 1'b0);
        check("R1 cfg_err", cfg_err_o, 1'b0);
        ovl_en_i = 1'b1;
        fill_bytes_i = '0;
        tick();
        check("R1 zero marks keep hi off", hi_req_o, 1'b0);
    endtask

    task automatic t_hysteresis();
        ovl_en_i = 1'b1;
        fill_bytes_i = 11'd600;
        commit(4'd4, 4'd8);
        tick();
        check("R9 above band", hi_req_o, 1'b0);
        fill_bytes_i = 11'd300; tick();
        check("R9 inside band from above", hi_req_o, 1'b0);
        fill_bytes_i = 11'd257; tick();
        check("R9 one above start", hi_req_o, 1'b0);
        fill_bytes_i = 11'd256; tick();
        check("R3 at start", hi_req_o, 1'b1);
        fill_bytes_i = 11'd400; tick();
        check("R4 hold mid", hi_req_o, 1'b1);
        fill_bytes_i = 11'd511; tick();
        check("R4 hold just below end", hi_req_o, 1'b1);
        fill_bytes_i = 11'd512; tick();
        check("R4 clear at end", hi_req_o, 1'b0);
        fill_bytes_i = 11'd300; tick();
        check("R9 no re-arm inside band", hi_req_o, 1'b0);
    endtask

    task automatic t_normal();
        ovl_en_i = 1'b1;
        fill_bytes_i = 11'd1023; tick();
        check("R8 room left", norm_req_o, 1'b1);
        fill_bytes_i = 11'd1024; tick();
        check("R8 full", norm_req_o, 1'b0);
        fill_bytes_i = 11'd0; tick();
        check("R8 empty", norm_req_o, 1'b1);
    endtask

    task automatic t_shadow();
        ovl_en_i = 1'b1;
        fill_bytes_i = 11'd600;
        commit(4'd4, 4'd8);
        tick();
        start_lvl_i = 4'd10;
        end_lvl_i   = 4'd12;
        tick();
        check("R2 uncommitted marks ignored", hi_req_o, 1'b0);
        start_lvl_i = 4'd9;
        end_lvl_i   = 4'd9;
        tick();
        check("R2 uncommitted bad cfg ignored", cfg_err_o, 1'b0);
        commit(4'd10, 4'd12);
        check("R2 old marks used on strobe edge", hi_req_o, 1'b0);
        tick();
        check("R2 new marks active after strobe", hi_req_o, 1'b1);
    endtask

    task automatic t_end_zero();
        ovl_en_i = 1'b1;
        fill_bytes_i = 11'd0;
        commit(4'd4, 4'd0);
        tick();
        check("R5 end zero no request", hi_req_o, 1'b0);
        check("R5 end zero no error", cfg_err_o, 1'b0);
        tick();
        check("R5 stays off", hi_req_o, 1'b0);
    endtask

    task automatic t_cfg_err();
        ovl_en_i = 1'b1;
        fill_bytes_i = 11'd0;
        commit(4'd8, 4'd8);
        check("R6 start equal end flags", cfg_err_o, 1'b1);
        tick();
        check("R6 equal marks suppress", hi_req_o, 1'b0);
        commit(4'd0, 4'd5);
        check("R6 start zero flags", cfg_err_o, 1'b1);
        tick();
        check("R6 start zero suppress", hi_req_o, 1'b0);
        commit(4'd3, 4'd5);
        check("R6 valid marks clear flag", cfg_err_o, 1'b0);
        tick();
        check("R3 request with valid marks", hi_req_o, 1'b1);
        commit(4'd6, 4'd5);
        check("R6 inverted flags", cfg_err_o, 1'b1);
        check("R6 still old marks on strobe edge", hi_req_o, 1'b1);
        tick();
        check("R6 inverted suppress", hi_req_o, 1'b0);
    endtask

    task automatic t_ovl_off();
        fill_bytes_i = 11'd100;
        ovl_en_i = 1'b1;
        commit(4'd4, 4'd8);
        tick();
        check("R3 low fill requests", hi_req_o, 1'b1);
        ovl_en_i = 1'b0; tick();
        check("R7 overlay off hi", hi_req_o, 1'b0);
        check("R7 overlay off norm", norm_req_o, 1'b0);
        ovl_en_i = 1'b1; tick();
        check("R7 overlay back on", hi_req_o, 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_hysteresis();
        t_normal();
        t_shadow();
        t_end_zero();
        t_cfg_err();
        t_ovl_off();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule